// File: doc/BRIEF.md
# Serial Carry-Save Merge and Product Deserializer

This block sits at the tail of a sequential multiplier. The accumulator ahead of it delivers the product in redundant carry-save form, one group per cycle starting at the least significant end. Each group holds two sum bits and one carry bit. The block resolves every group into two ordinary binary bits, keeping a single carry register between cycles so that carries move toward the most significant end. It packs the resulting bit pairs into a parallel product word through a shift register that advances two positions per accepted group.

Within a group, the sum bit `in_s0` has weight 1, and both `in_s1` and `in_c0` have weight 2. A start marker begins a new product and forces the incoming carry to zero. Once the product has received its full count of groups, the word is complete and a one-cycle strobe announces it. Any carry out of the top bit position is dropped. The next product then begins with a clear carry, whether or not it carries a marker.

Top module: `csm_merge_deser`

## Requirements
- R1: While reset is asserted, and right after it is released, `prod` is all zeros and `done` is 0.
- R2: The lower bit of each produced pair equals `in_s0` XOR the incoming carry.
- R3: The upper bit of each pair equals `in_s1` XOR `in_c0` XOR (`in_s0` AND incoming carry). The majority of `in_s1`, `in_c0` and that AND term becomes the incoming carry of the next accepted group.
- R4: A group accepted with `in_first` high uses an incoming carry of 0 and is counted as pair 0 of a new product, even if a product is partly received.
- R5: Each accepted group shifts `prod` right by two bits. The new pair {upper, lower} enters at bits [P_W-1:P_W-2]. After P_W/2 groups, pair 0 sits in bits [1:0].
- R6: `done` is high for exactly one cycle, the cycle after the (P_W/2)-th group of a product is accepted. In that cycle, `prod` equals the sum over groups k of (s0 + 2*s1 + 2*c0) * 4^k, modulo 2^P_W.
- R7: The carry out of the top pair is discarded. A group arriving right after a completed product, without a marker, starts a new product with incoming carry 0.
- R8: In a cycle with `in_valid` low, the inputs are ignored. `prod`, the held carry and the group count keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A carry-save group is present this cycle |
| in_first | input | 1 | This group starts a new product |
| in_s0 | input | 1 | Sum bit of weight 1 |
| in_s1 | input | 1 | Sum bit of weight 2 |
| in_c0 | input | 1 | Carry bit of weight 2 |
| prod | output | P_W | Parallel product word (P_W = A_W + B_W) |
| done | output | 1 | One-cycle strobe: `prod` holds a complete product |

## Verification
The hardest case to reach from the ports is a carry that has to travel across many groups. Only patterns such as long runs with every bit set keep the held carry at 1 from group to group, and a carry that is never cleared properly shows up only when a product ends or restarts with that carry still at 1. The stimulus therefore sends saturated all-ones products back to back without a marker. It breaks off a partial product with a fresh marker while the carry is set, and it scatters idle gaps through random traffic so that the held carry has to survive stalls.

// File: rtl/csm_pkg.sv
package csm_pkg;
   // selects how the two-bit merge cell is expressed
   localparam int CSM_ADD_GATES = 0;
   localparam int CSM_ADD_ARITH = 1;

   typedef struct packed {
      logic s0;   // weight 1
      logic s1;   // weight 2
      logic c0;   // weight 2
   } csm_grp_t;

   typedef struct packed {
      logic hi;
      logic lo;
   } csm_pair_t;
endpackage

// File: rtl/csm_pair_adder.sv
module csm_pair_adder
   import csm_pkg::*;
#(
   parameter int ADD_IMPL = CSM_ADD_GATES
) (
   input  csm_grp_t  grp,
   input  logic      cin,
   output csm_pair_t pair,
   output logic      cout
);
   generate
      if (ADD_IMPL == CSM_ADD_GATES) begin : g_gates
         logic h_carry;
         logic x_upper;
         always_comb begin
            h_carry = grp.s0 & cin;
            x_upper = grp.s1 ^ grp.c0;
            pair.lo = grp.s0 ^ cin;
            pair.hi = x_upper ^ h_carry;
            cout    = (grp.s1 & grp.c0) | (h_carry & x_upper);
         end
      end else if (ADD_IMPL == CSM_ADD_ARITH) begin : g_arith
         logic [2:0] total;
         always_comb begin
            total   = 3'(grp.s0) + 3'(cin) + (3'(grp.s1) << 1) + (3'(grp.c0) << 1);
            pair.lo = total[0];
            pair.hi = total[1];
            cout    = total[2];
         end
      end else begin : g_bad_impl
         $error("csm_pair_adder: unknown ADD_IMPL %0d", ADD_IMPL);
      end
   endgenerate
endmodule

// File: rtl/csm_group_ctrl.sv
module csm_group_ctrl #(
   parameter int PAIRS = 8,
   localparam int CNT_W = $clog2(PAIRS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_first,
   input  logic cout,
   output logic cin,
   output logic done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             carry_q;
   logic             done_q;
   logic             fresh;
   logic             last;

   always_comb begin
      fresh    = in_first || (cnt_q == '0);
      cin      = fresh ? 1'b0 : carry_q;
      cnt_next = in_first ? CNT_W'(1) : cnt_q + CNT_W'(1);
      last     = (cnt_next == CNT_W'(PAIRS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         carry_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= in_valid && last;
         if (in_valid) begin
            if (last) begin
               cnt_q   <= '0;
               carry_q <= 1'b0;
            end else begin
               cnt_q   <= cnt_next;
               carry_q <= cout;
            end
         end
      end
   end

   assign done = done_q;
endmodule

// File: rtl/csm_pair_shifter.sv
module csm_pair_shifter
   import csm_pkg::*;
#(
   parameter int PAIRS = 8,
   localparam int W = 2 * PAIRS
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      shift_en,
   input  csm_pair_t pair_in,
   output logic [W-1:0] word
);
   genvar g;
   generate
      for (g = 0; g < PAIRS; g++) begin : g_slot
         logic [1:0] slot_q;
         logic [1:0] slot_d;
         if (g == PAIRS - 1) begin : g_top
            assign slot_d = {pair_in.hi, pair_in.lo};
         end else begin : g_mid
            assign slot_d = word[2*g+3:2*g+2];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= 2'b00;
            end else if (shift_en) begin
               slot_q <= slot_d;
            end
         end
         assign word[2*g+1:2*g] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/csm_merge_deser.sv
module csm_merge_deser
   import csm_pkg::*;
#(
   parameter int A_W      = 8,
   parameter int B_W      = 8,
   parameter int ADD_IMPL = CSM_ADD_GATES,
   localparam int P_W     = A_W + B_W,
   localparam int PAIRS   = P_W / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_first,
   input  logic           in_s0,
   input  logic           in_s1,
   input  logic           in_c0,
   output logic [P_W-1:0] prod,
   output logic           done
);
   generate
      if ((P_W % 2) != 0) begin : g_odd_width
         $error("csm_merge_deser: A_W + B_W must be even, got %0d", P_W);
      end
      if (P_W < 4) begin : g_narrow
         $error("csm_merge_deser: product width must be at least 4, got %0d", P_W);
      end
   endgenerate

   csm_grp_t  grp;
   csm_pair_t pair;
   logic      cin;
   logic      cout;

   assign grp = '{s0: in_s0, s1: in_s1, c0: in_c0};

   csm_pair_adder #(.ADD_IMPL(ADD_IMPL)) u_adder (
      .grp  (grp),
      .cin  (cin),
      .pair (pair),
      .cout (cout)
   );

   csm_group_ctrl #(.PAIRS(PAIRS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_first (in_first),
      .cout     (cout),
      .cin      (cin),
      .done     (done)
   );

   csm_pair_shifter #(.PAIRS(PAIRS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .pair_in  (pair),
      .word     (prod)
   );
endmodule

// File: rtl/csm_merge_deser_chk.sv
module csm_merge_deser_chk #(
   parameter int P_W = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_first,
   input logic           in_s0,
   input logic           in_s1,
   input logic           in_c0,
   input logic [P_W-1:0] prod,
   input logic           done
);
   // R5: older pairs move down two places on every accepted group
   p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> prod[P_W-3:0] == $past(prod[P_W-1:2]));

   // R4: a marked group sees a zero incoming carry
   p_marker_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first) |=>
         (prod[P_W-2] == $past(in_s0)) && (prod[P_W-1] == $past(in_s1 ^ in_c0)));

   // R8: idle cycles leave the word untouched
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(prod));

   // R6: the strobe lasts a single cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: the strobe only follows an accepted group
   p_done_after_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid));
endmodule

bind csm_merge_deser csm_merge_deser_chk #(.P_W(P_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_first (in_first),
   .in_s0    (in_s0),
   .in_s1    (in_s1),
   .in_c0    (in_c0),
   .prod     (prod),
   .done     (done)
);

// File: tb/csm_merge_deser_bench.sv
module csm_merge_deser_bench;
   localparam int A_W   = 8;
   localparam int B_W   = 8;
   localparam int P_W   = A_W + B_W;
   localparam int PAIRS = P_W / 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_first = 1'b0;
   logic           in_s0 = 1'b0;
   logic           in_s1 = 1'b0;
   logic           in_c0 = 1'b0;
   logic [P_W-1:0] prod;
   logic           done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   csm_merge_deser #(.A_W(A_W), .B_W(B_W)) u_csm_merge_deser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_s0(in_s0), .in_s1(in_s1), .in_c0(in_c0), .prod(prod), .done(done)
   );

   // behavioural reference: integer arithmetic per group, running value per product
   logic [P_W-1:0] m_prod = '0;
   logic [P_W-1:0] m_word = '0;
   int             m_cnt = 0;
   int             m_cin = 0;
   bit             m_done = 0;
   longint         m_acc = 0;

   always @(posedge clk or negedge rst_n) begin
      int     v;
      int     k;
      bit     fresh;
      longint nacc;
      if (!rst_n) begin
         m_prod <= '0; m_cnt <= 0; m_cin <= 0; m_done <= 0; m_acc <= 0;
      end else begin
         m_done <= 0;
         if (in_valid) begin
            fresh = in_first || (m_cnt == 0);
            k     = in_first ? 0 : m_cnt;
            v     = int'(in_s0) + 2 * int'(in_s1) + 2 * int'(in_c0) + (fresh ? 0 : m_cin);
            nacc  = (fresh ? 64'sd0 : m_acc)
                    + (longint'(int'(in_s0) + 2 * int'(in_s1) + 2 * int'(in_c0)) << (2 * k));
            m_prod <= {2'(v), m_prod[P_W-1:2]};
            m_acc  <= nacc;
            if (k + 1 == PAIRS) begin
               m_done <= 1; m_cnt <= 0; m_cin <= 0;
               m_word <= P_W'(nacc);
            end else begin
               m_cnt <= k + 1; m_cin <= v >> 2;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [P_W-1:0] act,
                      input logic [P_W-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(prod == m_prod, "R5 word", prod, m_prod);
         chk(done == m_done, "R6 strobe", P_W'(done), P_W'(m_done));
         if (m_done) chk(prod == m_word, "R6 R7 full product", prod, m_word);
      end
   end

   task automatic send(input bit s0, input bit s1, input bit c0, input bit first);
      in_valid = 1'b1; in_first = first; in_s0 = s0; in_s1 = s1; in_c0 = c0;
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0;
   endtask

   task automatic idle(input int n);
      in_s0 = 1'b1; in_s1 = 1'b1; in_c0 = 1'b1; in_first = 1'b1;
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
      in_first = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [P_W-1:0] snap;
      repeat (3) @(negedge clk);
      chk(prod == '0, "R1 prod in reset", prod, '0);
      chk(done == 1'b0, "R1 done in reset", P_W'(done), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(prod == '0 && !done, "R1 after release", prod, '0);

      // R2 / R3: two hand-worked groups
      send(1, 1, 1, 1);   // 1+2+2 = 5 -> pair 01, carry 1
      send(1, 0, 0, 0);   // 1+0+1 = 2 -> pair 10 (lo R2, hi R3)
      chk(prod[P_W-1:P_W-2] == 2'b10, "R2 R3 pair with carry",
          P_W'(prod[P_W-1:P_W-2]), P_W'(2'b10));
      chk(prod[P_W-3:P_W-4] == 2'b01, "R3 first pair", P_W'(prod[P_W-3:P_W-4]), P_W'(2'b01));
      for (int i = 2; i < PAIRS; i++) send(0, 0, 0, 0);
      chk(done && prod[3:0] == 4'b1001, "R5 pair 0 at bottom", prod, P_W'(16'h0009));

      // saturated product: carry held at 1 across every group
      for (int i = 0; i < PAIRS; i++) send(1, 1, 1, i == 0);
      chk(done && prod == 16'hAAA9, "R6 all-ones product", prod, 16'hAAA9);

      // R7: back-to-back without a marker, top carry dropped
      for (int i = 0; i < PAIRS; i++) send(1, 1, 1, 0);
      chk(done && prod == 16'hAAA9, "R7 carry discarded", prod, 16'hAAA9);

      // R8: idle cycles with busy-looking inputs
      send(1, 1, 1, 1);
      send(1, 1, 1, 0);
      snap = prod;
      idle(5);
      chk(prod == snap, "R8 idle hold", prod, snap);
      for (int i = 2; i < PAIRS; i++) send(1, 1, 1, 0);
      chk(done && prod == 16'hAAA9, "R8 carry kept over idle", prod, 16'hAAA9);

      // R4: marker breaks off a partial product while carry is set
      for (int i = 0; i < 3; i++) send(1, 1, 1, i == 0);
      for (int i = 0; i < PAIRS; i++) send(1, 1, 1, i == 0);
      chk(done && prod == 16'hAAA9, "R4 restart mid-product", prod, 16'hAAA9);

      // random traffic with gaps and occasional early markers
      for (int p = 0; p < 60; p++) begin
         for (int i = 0; i < PAIRS; i++) begin
            send(1'($urandom), 1'($urandom), 1'($urandom),
                 (i == 0) ? 1'($urandom) : (($urandom % 23) == 0));
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
         end
      end
      idle(3);
      finish_run();
   end
endmodule